// File: doc/BRIEF.md
# Calendar Time Counter Register Block

This block keeps wall-clock time as eight separate counters: second, minute, hour, day of month, day of week, day of year, month and year. A tick-enable input comes from a prescaler outside the block. An internal sub-second divider counts those ticks and advances the seconds counter once every `DIV_COUNT` ticks. Carries then ripple upward through the calendar. Month lengths include a leap-year February, chosen by the year modulo 4.

Software reaches the block over a plain 32-bit register bus: address, write enable, write data, and combinational read data. Each counter has its own read/write word. Three read-only words pack the fields together, so a full timestamp takes three reads. A control word enables counting and can hold the sub-second divider in reset. Five scratch words store software data. An eight-bit pulse output flags every field that advanced, one cycle per advance.

To set the time safely, software first writes seconds to zero. It then writes the upper fields and writes the real seconds value last. Because the consolidated words follow the live counters, a carry that lands between two reads shows up as a changed value on re-reading.

Top module: `cal_timer_regs`

## Requirements
- R1: After reset, every counter reads as follows: seconds 0, minutes 0, hours 0, day of month 1, day of week 0, day of year 1, month 1 and year 0. The control word at 0x08 and all scratch words read 0.
- R2: The control word at 0x08 stores bit 0 (count enable), bit 1 (divider reset) and bit 4 (calibration disable). Its other bits always read 0.
- R3: Seconds advance once per `DIV_COUNT` accepted ticks, and only while enable is 1 and divider reset is 0. While divider reset is 1, the sub-second count is held at zero, so a full `DIV_COUNT` ticks are needed after release.
- R4: Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and start a new day.
- R5: On a new day, day of week wraps 6→0 and day of year increments. Day of month wraps from the month length back to 1 and carries into the month.
- R6: Month length is 31 days, except 30 for months 4, 6, 9 and 11. February (month 2) has 29 days when year mod 4 is 0 and 28 days otherwise.
- R7: Month wraps 12→1 and increments the year. Day of year returns to 1 after 366 in years divisible by 4 and after 365 otherwise.
- R8: Field words sit at 0x20 (sec), 0x24 (min), 0x28 (hour), 0x2C (day of month), 0x30 (day of week), 0x34 (day of year), 0x38 (month) and 0x3C (year). A write loads the low bits that fit the field: widths 6, 6, 5, 5, 3, 9, 4 and 12. A write wins over an increment of the same field in the same cycle.
- R9: Consolidated word 0x14 holds sec[5:0], min[13:8], hour[20:16] and day of week[26:24]. Word 0x18 holds day of month[4:0], month[11:8] and year[27:16]. Word 0x1C holds day of year in its low bits. All three reflect the counters of the current cycle.
- R10: `inc_pulse` bit i matches the field order of R8, with bit 0 for seconds and bit 7 for year. Bit i is high for one cycle, in the first cycle the advanced value is visible. An advance overridden by a write gives no pulse.
- R11: The scratch words at 0x44, 0x48, 0x4C, 0x50 and 0x54 keep the last value written and have no effect on counting.
- R12: After seconds are written to 0, no carry into minutes occurs until 60 seconds have elapsed, so software can rewrite the upper fields undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One prescaler tick per cycle when high |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| inc_pulse | output | 8 | One-cycle advance flag per field |

## Verification
The embedded assertions watch four things on every cycle:
- the divider is held at zero under divider reset;
- seconds and day of month wrap to their lower bounds;
- a field write overrides a concurrent increment;
- no field pulse appears without a seconds tick behind it.

Only the bench scenarios can show the calendar arithmetic end to end. These cover leap and common Februaries, 30-day months, year-end day-of-year wrap, the bit packing of the consolidated words, scratch retention and the seconds-zero safe-write sequence. Each scenario starts from preset boundary values.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOM_W  = 5;
  localparam int DOW_W  = 3;
  localparam int DOY_W  = 9;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 12;

  localparam int FI_SEC  = 0;
  localparam int FI_MIN  = 1;
  localparam int FI_HOUR = 2;
  localparam int FI_DOM  = 3;
  localparam int FI_DOW  = 4;
  localparam int FI_DOY  = 5;
  localparam int FI_MON  = 6;
  localparam int FI_YEAR = 7;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [DOW_W-1:0]  DOW_LAST  = DOW_W'(6);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DOY_W-1:0]  doy;
    logic [DOW_W-1:0]  dow;
    logic [DOM_W-1:0]  dom;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  function automatic logic leap_year(input logic [YEAR_W-1:0] y);
    return (y[1:0] == 2'b00);
  endfunction

  function automatic logic [DOM_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                 input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                     return leap_year(y) ? DOM_W'(29) : DOM_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11:  return DOM_W'(30);
      default:                  return DOM_W'(31);
    endcase
  endfunction

  function automatic logic [DOY_W-1:0] year_len(input logic [YEAR_W-1:0] y);
    return leap_year(y) ? DOY_W'(366) : DOY_W'(365);
  endfunction

  function automatic logic [31:0] pack_clock(input cal_time_t t);
    return {5'b0, t.dow, 3'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic logic [31:0] pack_date(input cal_time_t t);
    return {4'b0, t.year, 4'b0, t.mon, 3'b0, t.dom};
  endfunction

  function automatic logic [31:0] pack_yday(input cal_time_t t);
    return {{(32-DOY_W){1'b0}}, t.doy};
  endfunction
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int DIV_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic div_hold,
  input  logic tick_en,
  output logic sec_tick
);
  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] sub_cnt;
  logic             accept;

  assign accept   = run_en && !div_hold && tick_en;
  assign sec_tick = accept && (sub_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || div_hold) begin
      sub_cnt <= '0;
    end else if (accept) begin
      sub_cnt <= (sub_cnt == CNT_LAST) ? '0 : sub_cnt + 1'b1;
    end
  end

  // R3: divider reset keeps the sub-second count at zero
  assert_div_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> (sub_cnt == '0));
endmodule

// File: rtl/cal_counters.sv
module cal_counters
  import cal_pkg::*;
#(
  parameter int WR_W = YEAR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_tick,
  input  logic [NUM_FIELDS-1:0] wr_en,
  input  logic [WR_W-1:0]       wr_data,
  output cal_time_t             now,
  output logic [NUM_FIELDS-1:0] inc_pulse
);
  logic [NUM_FIELDS-1:0] adv;
  logic wrap_sec, wrap_min, wrap_hour, wrap_dow, wrap_dom, wrap_doy, wrap_mon;
  logic new_day;

  assign wrap_sec  = now.sec  >= SEC_LAST;
  assign wrap_min  = now.min  >= MIN_LAST;
  assign wrap_hour = now.hour >= HOUR_LAST;
  assign wrap_dow  = now.dow  >= DOW_LAST;
  assign wrap_dom  = now.dom  >= month_len(now.mon, now.year);
  assign wrap_doy  = now.doy  >= year_len(now.year);
  assign wrap_mon  = now.mon  >= MON_LAST;

  assign adv[FI_SEC]  = sec_tick;
  assign adv[FI_MIN]  = adv[FI_SEC] && wrap_sec;
  assign adv[FI_HOUR] = adv[FI_MIN] && wrap_min;
  assign new_day      = adv[FI_HOUR] && wrap_hour;
  assign adv[FI_DOM]  = new_day;
  assign adv[FI_DOW]  = new_day;
  assign adv[FI_DOY]  = new_day;
  assign adv[FI_MON]  = new_day && wrap_dom;
  assign adv[FI_YEAR] = adv[FI_MON] && wrap_mon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now       <= '0;
      now.dom   <= DOM_W'(1);
      now.doy   <= DOY_W'(1);
      now.mon   <= MON_W'(1);
      inc_pulse <= '0;
    end else begin
      inc_pulse <= adv & ~wr_en;

      if (wr_en[FI_SEC])       now.sec <= wr_data[SEC_W-1:0];
      else if (adv[FI_SEC])    now.sec <= wrap_sec ? '0 : now.sec + 1'b1;

      if (wr_en[FI_MIN])       now.min <= wr_data[MIN_W-1:0];
      else if (adv[FI_MIN])    now.min <= wrap_min ? '0 : now.min + 1'b1;

      if (wr_en[FI_HOUR])      now.hour <= wr_data[HOUR_W-1:0];
      else if (adv[FI_HOUR])   now.hour <= wrap_hour ? '0 : now.hour + 1'b1;

      if (wr_en[FI_DOM])       now.dom <= wr_data[DOM_W-1:0];
      else if (adv[FI_DOM])    now.dom <= wrap_dom ? DOM_W'(1) : now.dom + 1'b1;

      if (wr_en[FI_DOW])       now.dow <= wr_data[DOW_W-1:0];
      else if (adv[FI_DOW])    now.dow <= wrap_dow ? '0 : now.dow + 1'b1;

      if (wr_en[FI_DOY])       now.doy <= wr_data[DOY_W-1:0];
      else if (adv[FI_DOY])    now.doy <= wrap_doy ? DOY_W'(1) : now.doy + 1'b1;

      if (wr_en[FI_MON])       now.mon <= wr_data[MON_W-1:0];
      else if (adv[FI_MON])    now.mon <= wrap_mon ? MON_W'(1) : now.mon + 1'b1;

      if (wr_en[FI_YEAR])      now.year <= wr_data[YEAR_W-1:0];
      else if (adv[FI_YEAR])   now.year <= now.year + 1'b1;
    end
  end

  // R4: a counted step from 59 seconds lands on 0
  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en[FI_SEC] && now.sec == SEC_LAST) |=> (now.sec == '0));

  // R5: day of month returns to 1 after the last day of the month
  assert_dom_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_day && !wr_en[FI_DOM] && now.dom == month_len(now.mon, now.year))
      |=> (now.dom == DOM_W'(1)));

  // R8: a field write wins over a same-cycle increment
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[FI_SEC] |=> (now.sec == $past(wr_data[SEC_W-1:0])));

  // R10: no field pulse without a seconds tick one cycle earlier
  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|inc_pulse) |-> $past(sec_tick));
endmodule

// File: rtl/cal_timer_regs.sv
module cal_timer_regs
  import cal_pkg::*;
#(
  parameter int DIV_COUNT   = 4,
  parameter int ADDR_W      = 8,
  parameter int NUM_SCRATCH = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_FIELDS-1:0] inc_pulse
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] ADDR_PACK0   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] ADDR_PACK1   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] ADDR_PACK2   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] FIELD_BASE   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] SCRATCH_BASE = ADDR_W'(8'h44);

  logic ctrl_run, ctrl_div_rst, ctrl_cal_off;
  logic sec_tick;
  logic [NUM_FIELDS-1:0] field_wr;
  cal_time_t now;
  logic [31:0] field_rd [NUM_FIELDS];
  logic [31:0] scratch_q [NUM_SCRATCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_run     <= 1'b0;
      ctrl_div_rst <= 1'b0;
      ctrl_cal_off <= 1'b0;
    end else if (bus_we && bus_addr == ADDR_CTRL) begin
      ctrl_run     <= bus_wdata[0];
      ctrl_div_rst <= bus_wdata[1];
      ctrl_cal_off <= bus_wdata[4];
    end
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field_dec
    assign field_wr[gi] = bus_we && (bus_addr == FIELD_BASE + ADDR_W'(4 * gi));
  end

  for (genvar gj = 0; gj < NUM_SCRATCH; gj++) begin : g_scratch
    always_ff @(posedge clk) begin
      if (!rst_n)
        scratch_q[gj] <= '0;
      else if (bus_we && bus_addr == SCRATCH_BASE + ADDR_W'(4 * gj))
        scratch_q[gj] <= bus_wdata;
    end
  end

  cal_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (ctrl_run),
    .div_hold (ctrl_div_rst),
    .tick_en  (tick_en),
    .sec_tick (sec_tick)
  );

  cal_counters #(.WR_W(YEAR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .wr_en     (field_wr),
    .wr_data   (bus_wdata[YEAR_W-1:0]),
    .now       (now),
    .inc_pulse (inc_pulse)
  );

  assign field_rd[FI_SEC]  = 32'(now.sec);
  assign field_rd[FI_MIN]  = 32'(now.min);
  assign field_rd[FI_HOUR] = 32'(now.hour);
  assign field_rd[FI_DOM]  = 32'(now.dom);
  assign field_rd[FI_DOW]  = 32'(now.dow);
  assign field_rd[FI_DOY]  = 32'(now.doy);
  assign field_rd[FI_MON]  = 32'(now.mon);
  assign field_rd[FI_YEAR] = 32'(now.year);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL)  bus_rdata = {27'b0, ctrl_cal_off, 2'b0, ctrl_div_rst, ctrl_run};
    if (bus_addr == ADDR_PACK0) bus_rdata = pack_clock(now);
    if (bus_addr == ADDR_PACK1) bus_rdata = pack_date(now);
    if (bus_addr == ADDR_PACK2) bus_rdata = pack_yday(now);
    for (int i = 0; i < NUM_FIELDS; i++)
      if (bus_addr == FIELD_BASE + ADDR_W'(4 * i)) bus_rdata = field_rd[i];
    for (int j = 0; j < NUM_SCRATCH; j++)
      if (bus_addr == SCRATCH_BASE + ADDR_W'(4 * j)) bus_rdata = scratch_q[j];
  end

  // R3: without run enable no seconds step is produced
  assert_no_step_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_run |=> $stable(now.sec) || $past(field_wr[FI_SEC]));
endmodule

// File: tb/cal_timer_regs_bench.sv
module cal_timer_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  inc_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_pulse;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_timer_regs #(.DIV_COUNT(DIV)) u_cal_timer_regs (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inc_pulse(inc_pulse)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] got;
      it = sb_q.pop_front();
      got = it.is_pulse ? {24'b0, inc_pulse} : bus_rdata;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_pulse = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse_is(input logic [7:0] e, input string tag);
    sb_item_t it;
    it.is_pulse = 1'b1; it.addr = 8'h00; it.exp = {24'b0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick_once();
    @(posedge clk); #1; tick_en = 1'b1;
    @(posedge clk); #1; tick_en = 1'b0;
  endtask

  task automatic one_sec();
    for (int k = 0; k < DIV; k++) tick_once();
  endtask

  task automatic set_cal(input int yr, input int mo, input int dm, input int dw,
                         input int dy, input int hr, input int mi, input int sc);
    wr(8'h20, 0);
    wr(8'h3C, yr); wr(8'h38, mo); wr(8'h2C, dm); wr(8'h30, dw);
    wr(8'h34, dy); wr(8'h28, hr); wr(8'h24, mi); wr(8'h20, sc);
  endtask

  function automatic logic [31:0] exp_w0(int s, int m, int h, int w);
    return s + m * 256 + h * 65536 + w * 16777216;
  endfunction

  function automatic logic [31:0] exp_w1(int d, int mo, int y);
    return d + mo * 256 + y * 65536;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h20, 0, "R1 sec");
    rd(8'h2C, 1, "R1 dom");
    rd(8'h34, 1, "R1 doy");
    rd(8'h38, 1, "R1 month");
    rd(8'h3C, 0, "R1 year");
    rd(8'h08, 0, "R1 ctrl");
    rd(8'h44, 0, "R1 scratch");

    // R2 control bits
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h13, "R2 ctrl readback");
    wr(8'h08, 32'h0);

    // R3 disabled: no counting
    one_sec(); one_sec();
    rd(8'h20, 0, "R3 disabled no step");

    // R3 enabled: one second per DIV ticks, R10 seconds pulse
    wr(8'h08, 32'h1);
    one_sec();
    pulse_is(8'h01, "R10 sec pulse");
    rd(8'h20, 1, "R3 one step");

    // R3 divider reset clears partial count
    tick_once(); tick_once();
    wr(8'h08, 32'h3);
    tick_once(); tick_once();
    wr(8'h08, 32'h1);
    tick_once(); tick_once();
    rd(8'h20, 1, "R3 divider held at zero");
    tick_once(); tick_once();
    rd(8'h20, 2, "R3 full count after release");

    // R8 field width masking
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h1F, "R8 hour mask");

    // R4 R5 R6 common-year February end
    set_cal(2023, 2, 28, 6, 59, 23, 59, 59);
    one_sec();
    pulse_is(8'h7F, "R10 full carry pulse");
    rd(8'h20, 0, "R4 sec wrap");
    rd(8'h24, 0, "R4 min wrap");
    rd(8'h28, 0, "R4 hour wrap");
    rd(8'h30, 0, "R5 dow wrap");
    rd(8'h34, 60, "R5 doy step");
    rd(8'h14, exp_w0(0, 0, 0, 0), "R9 word0 zero");
    rd(8'h18, exp_w1(1, 3, 2023), "R6 R9 feb 28 to mar 1");
    rd(8'h1C, 60, "R9 word2");

    // R6 leap February
    set_cal(2024, 2, 28, 3, 59, 23, 59, 59);
    one_sec();
    pulse_is(8'h3F, "R10 day pulse no month");
    rd(8'h18, exp_w1(29, 2, 2024), "R6 leap feb 29");
    wr(8'h28, 23); wr(8'h24, 59); wr(8'h20, 59);
    one_sec();
    rd(8'h18, exp_w1(1, 3, 2024), "R6 leap feb to mar");
    rd(8'h34, 61, "R5 doy after leap day");

    // R6 thirty-day month
    set_cal(2023, 4, 30, 1, 120, 23, 59, 59);
    one_sec();
    rd(8'h18, exp_w1(1, 5, 2023), "R6 april end");

    // R7 leap year end
    set_cal(2024, 12, 31, 2, 366, 23, 59, 59);
    one_sec();
    pulse_is(8'hFF, "R10 year pulse");
    rd(8'h18, exp_w1(1, 1, 2025), "R7 year wrap");
    rd(8'h34, 1, "R7 doy 366 wrap");
    rd(8'h30, 3, "R5 dow step");

    // R7 common year end
    set_cal(2025, 12, 31, 4, 365, 23, 59, 59);
    one_sec();
    rd(8'h34, 1, "R7 doy 365 wrap");
    rd(8'h3C, 2026, "R7 year step");

    // R9 nonzero clock word
    wr(8'h30, 5); wr(8'h28, 13); wr(8'h24, 42); wr(8'h20, 7);
    rd(8'h14, exp_w0(7, 42, 13, 5), "R9 word0 packing");

    // R8 write wins over same-cycle increment
    tick_once(); tick_once(); tick_once();
    @(posedge clk); #1;
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'd20;
    @(posedge clk); #1;
    tick_en = 1'b0; bus_we = 1'b0;
    pulse_is(8'h00, "R8 R10 overridden step no pulse");
    rd(8'h20, 20, "R8 write wins");
    rd(8'h24, 42, "R8 min untouched");

    // R11 scratch storage
    wr(8'h44, 32'hA5A5_5A5A);
    wr(8'h54, 32'h1234_5678);
    wr(8'h4C, 32'hDEAD_BEEF);
    rd(8'h44, 32'hA5A5_5A5A, "R11 scratch0");
    rd(8'h54, 32'h1234_5678, "R11 scratch4");
    rd(8'h48, 0, "R11 scratch1 untouched");
    rd(8'h20, 20, "R11 no effect on seconds");

    // R12 seconds zero defers carry; R4 minute carry
    wr(8'h24, 10); wr(8'h20, 58);
    one_sec();
    wr(8'h20, 0);
    one_sec(); one_sec();
    rd(8'h20, 2, "R12 sec after zero write");
    rd(8'h24, 10, "R12 no minute carry");
    wr(8'h20, 59);
    one_sec();
    rd(8'h24, 11, "R4 minute carry");

    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule